// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits between the byte-level protocol engine of a serial memory and its storage array. The engine hands it each received data byte together with the word address it belongs to. The block stages these bytes in a one-page buffer. A per-entry valid mask records which buffer slots have actually been filled. When the engine reports a stop condition, the block copies the staged page into the array and then holds a busy flag for a programmable number of clock cycles, which models the self-timed write cycle.

The first byte into an empty buffer fixes the page and the starting slot. Every following byte goes to the next slot in that page, and the slot number wraps from the last slot back to the first. A host that sends more than a page of bytes therefore overwrites the earlier buffered entries. A hardware write-protect input locks the upper quarter of the address space. A commit aimed at a locked page writes nothing and still empties the buffer. While busy is high, the block ignores all of its inputs.

Top module: `page_commit_buf`

## Requirements
- R1: The first byte accepted into an empty buffer takes its page from word address bits [ADDR_W-1:5] and its slot from bits [4:0]. Each later byte goes to the slot after the previous one, and its address input is ignored.
- R2: The slot after 31 is 0 in the same page. A byte sent to a slot that already holds data replaces the earlier value, so with 40 bytes the last 8 win.
- R3: A commit writes only the slots that received data. All other array locations keep their contents, so partial pages are allowed.
- R4: A stop while the buffer is empty, as after an address-only dummy write, causes no array write, and busy stays low.
- R5: A stop that commits raises busy in the cycle after the stop is sampled. Busy then stays high for exactly WR_CYCLES cycles.
- R6: While busy is high, byte strobes and stop strobes are ignored. They neither extend busy nor enter the buffer.
- R7: A page is locked when the write-protect input is 1 at the stop and both address bits [ADDR_W-1:ADDR_W-2] are 1. A locked page causes no array write. With PROT_BUSY=0 it also raises no busy. With write-protect at 0, or with a lower address, the commit proceeds.
- R8: Array writes happen only while busy is high, with one write per filled slot, and all of them fall in the first 32 busy cycles.
- R9: After reset, busy is low, no array write is issued and the buffer is empty.
- R10: Every commit or locked stop empties the buffer, so the next byte starts a fresh page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | One-cycle strobe: a data byte has been received |
| byte_data | input | DATA_W | Received data byte |
| byte_addr | input | ADDR_W | Word address for the byte; used only when the buffer is empty |
| stop_vld | input | 1 | One-cycle strobe: a stop condition has been seen |
| wp | input | 1 | Write-protect for the upper quarter of the address space |
| busy | output | 1 | Write cycle in progress; inputs are ignored |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |

## Verification
On every cycle, the assertions check the following:
- array writes occur only during busy, and never to a locked page;
- a busy period ends only once its count has run out;
- an empty-buffer stop never starts busy;
- the staged mask stays frozen while busy and never loses bits outside a clear.

Slot placement, in-page wrap with overwrite, partial-page writes, busy length and the clearing of the buffer after a locked stop can only be shown by the bench. It compares the whole array against a reference model after directed and random sequences.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
   // Lock decision: protect pin high and address in the top quarter.
   function automatic logic pcb_locked(input logic wp_i, input logic [1:0] top2);
      return wp_i && (top2 == 2'b11);
   endfunction
endpackage

// File: rtl/pcb_stage.sv
module pcb_stage #(
   parameter int DATA_W     = 8,
   parameter int PAGE_BYTES = 32,
   parameter int PAGE_W     = 7,
   localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [PAGE_W-1:0]     wr_page,
   input  logic [OFF_W-1:0]      wr_off,
   input  logic [DATA_W-1:0]     wr_data,
   input  logic                  clr,
   input  logic [OFF_W-1:0]      rd_idx,
   output logic [DATA_W-1:0]     rd_data,
   output logic                  rd_vld,
   output logic [PAGE_W-1:0]     page_q,
   output logic [PAGE_BYTES-1:0] vmask
);
   logic [OFF_W-1:0]      ptr_q;
   logic [PAGE_BYTES-1:0] vld_q;
   logic [DATA_W-1:0]     ent_q [PAGE_BYTES];
   logic                  empty;
   logic [OFF_W-1:0]      off_eff;

   assign empty   = ~|vld_q;
   assign off_eff = empty ? wr_off : ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         vld_q  <= '0;
         page_q <= '0;
      end else if (clr) begin
         ptr_q <= '0;
         vld_q <= '0;
      end else if (wr_en) begin
         vld_q[off_eff] <= 1'b1;
         ptr_q          <= off_eff + 1'b1;   // wraps inside the page
         if (empty) page_q <= wr_page;
      end
   end

   for (genvar e = 0; e < PAGE_BYTES; e++) begin : g_ent
      always_ff @(posedge clk) begin
         if (wr_en && !clr && off_eff == OFF_W'(e)) ent_q[e] <= wr_data;
      end
   end

   assign rd_data = ent_q[rd_idx];
   assign rd_vld  = vld_q[rd_idx];
   assign vmask   = vld_q;

   AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((vld_q & $past(vld_q)) == $past(vld_q)))
      else $error("valid mask lost a bit without clear"); // R3
endmodule

// File: rtl/pcb_timer.sv
module pcb_timer #(
   parameter int WR_CYCLES = 2_500_000,
   localparam int CNT_W    = $clog2(WR_CYCLES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic             busy,
   output logic [CNT_W-1:0] cnt,
   output logic             done
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (start) begin
         busy <= 1'b1;
         cnt  <= '0;
      end else if (busy) begin
         if (cnt == CNT_W'(WR_CYCLES - 1)) busy <= 1'b0;
         else                              cnt  <= cnt + 1'b1;
      end
   end

   assign done = busy && (cnt == CNT_W'(WR_CYCLES - 1));

   AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(cnt) == CNT_W'(WR_CYCLES - 1))
      else $error("busy ended early"); // R5
   AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy)
      else $error("start while busy"); // R6
endmodule

// File: rtl/page_commit_buf.sv
module page_commit_buf
   import pcb_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int DATA_W     = 8,
   parameter int PAGE_BYTES = 32,
   parameter int WR_CYCLES  = 2_500_000,
   parameter bit PROT_BUSY  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_vld,
   input  logic [DATA_W-1:0] byte_data,
   input  logic [ADDR_W-1:0] byte_addr,
   input  logic              stop_vld,
   input  logic              wp,
   output logic              busy,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata
);
   localparam int OFF_W  = $clog2(PAGE_BYTES);
   localparam int PAGE_W = ADDR_W - OFF_W;
   localparam int CNT_W  = $clog2(WR_CYCLES + 1);

   if (PAGE_BYTES != (1 << OFF_W)) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two");
   end
   if (WR_CYCLES < PAGE_BYTES) begin : g_bad_time
      $error("WR_CYCLES must cover one write per page slot");
   end
   if (PAGE_W < 2) begin : g_bad_addr
      $error("ADDR_W too small for page plus quarter decode");
   end

   logic                  stop_take, byte_take, any_vld, locked;
   logic                  commit_go, prot_hit, start, clr, done;
   logic                  wen_q, wp_q, rd_vld, in_scan;
   logic [PAGE_W-1:0]     page_q;
   logic [PAGE_BYTES-1:0] vmask;
   logic [DATA_W-1:0]     rd_data;
   logic [CNT_W-1:0]      cnt;
   logic [OFF_W-1:0]      idx;

   assign stop_take = stop_vld && !busy;
   assign byte_take = byte_vld && !busy && !stop_vld;
   assign any_vld   = |vmask;
   assign locked    = pcb_locked(wp, page_q[PAGE_W-1 -: 2]);
   assign commit_go = stop_take && any_vld && !locked;
   assign prot_hit  = stop_take && any_vld && locked;

   if (PROT_BUSY) begin : g_prot_busy
      assign start = commit_go || prot_hit;
   end else begin : g_prot_quiet
      assign start = commit_go;
   end

   assign clr = done || prot_hit;

   pcb_stage #(
      .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES), .PAGE_W(PAGE_W)
   ) u_stage (
      .clk(clk), .rst_n(rst_n),
      .wr_en(byte_take),
      .wr_page(byte_addr[ADDR_W-1:OFF_W]),
      .wr_off(byte_addr[OFF_W-1:0]),
      .wr_data(byte_data),
      .clr(clr),
      .rd_idx(idx), .rd_data(rd_data), .rd_vld(rd_vld),
      .page_q(page_q), .vmask(vmask)
   );

   pcb_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(start),
      .busy(busy), .cnt(cnt), .done(done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wen_q <= 1'b0;
         wp_q  <= 1'b0;
      end else if (start) begin
         wen_q <= commit_go;
         wp_q  <= wp;
      end
   end

   assign idx       = cnt[OFF_W-1:0];
   assign in_scan   = busy && (cnt < CNT_W'(PAGE_BYTES));
   assign mem_we    = in_scan && wen_q && rd_vld;
   assign mem_addr  = {page_q, idx};
   assign mem_wdata = rd_data;

   AST_NO_WR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_we)
      else $error("array write outside busy"); // R8
   AST_WP_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> !pcb_locked(wp_q, mem_addr[ADDR_W-1 -: 2]))
      else $error("write to locked quarter"); // R7
   AST_EMPTY_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_vld && !busy && !any_vld) |=> !busy)
      else $error("empty stop started busy"); // R4
   AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> $stable(vmask))
      else $error("buffer changed while busy"); // R6
   AST_LOCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_hit && !PROT_BUSY) |=> !busy)
      else $error("locked stop raised busy"); // R7
endmodule

// File: tb/page_commit_buf_tb.sv
module page_commit_buf_tb;
   localparam int AW = 12;
   localparam int WRC = 40;
   localparam int MEMSZ = 1 << AW;

   logic clk = 0, rst_n = 0;
   logic byte_vld = 0, stop_vld = 0, wp = 0;
   logic [7:0] byte_data = 0;
   logic [AW-1:0] byte_addr = 0;
   logic busy, mem_we;
   logic [AW-1:0] mem_addr;
   logic [7:0] mem_wdata;

   int n_chk = 0, n_fail = 0, idle_we = 0, we_cnt = 0;
   bit fin = 0;
   logic [7:0] mem [MEMSZ];
   logic [7:0] exp_mem [MEMSZ];

   always #2 clk = ~clk;

   page_commit_buf #(.ADDR_W(AW), .DATA_W(8), .PAGE_BYTES(32),
      .WR_CYCLES(WRC), .PROT_BUSY(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_data(byte_data),
      .byte_addr(byte_addr), .stop_vld(stop_vld), .wp(wp), .busy(busy),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata));

   always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;
   always @(negedge clk) begin
      if (mem_we) we_cnt++;
      if (mem_we && !busy) idle_we++;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   function automatic int mem_diff();
      int d = 0;
      for (int i = 0; i < MEMSZ; i++) if (mem[i] !== exp_mem[i]) d++;
      return d;
   endfunction

   function automatic bit is_locked(input logic w, input logic [AW-1:0] a);
      return w && (a[AW-1:AW-2] == 2'b11);
   endfunction

   task automatic send_byte(input logic [AW-1:0] a, input logic [7:0] d);
      @(negedge clk); byte_vld = 1; byte_addr = a; byte_data = d;
      @(negedge clk); byte_vld = 0;
   endtask

   task automatic send_stop();
      @(negedge clk); stop_vld = 1;
      @(negedge clk); stop_vld = 0;
   endtask

   task automatic measure_busy(input bit inject, output int n);
      n = 0;
      while (busy && n < 1000) begin
         n++;
         if (inject) begin
            byte_vld = 1; byte_addr = AW'($urandom); byte_data = 8'($urandom);
            stop_vld = n[0];
         end
         @(negedge clk);
      end
      byte_vld = 0; stop_vld = 0;
   endtask

   // One write sequence: n bytes from address a, then stop with protect w.
   task automatic do_seq(input logic [AW-1:0] a, input int n, input logic w,
                         input bit inject, input string tag);
      logic [7:0] bd [32];
      bit bv [32];
      int off, nb, exp_busy, distinct;
      for (int i = 0; i < 32; i++) bv[i] = 0;
      off = int'(a[4:0]);
      for (int i = 0; i < n; i++) begin
         logic [7:0] d = 8'($urandom);
         int o = (off + i) % 32;
         bd[o] = d; bv[o] = 1;
         send_byte((i == 0) ? a : AW'($urandom), d);  // later addresses ignored (R1)
      end
      distinct = (n > 32) ? 32 : n;
      exp_busy = (n > 0 && !is_locked(w, a)) ? WRC : 0;
      if (exp_busy != 0)
         for (int i = 0; i < 32; i++)
            if (bv[i]) exp_mem[{a[AW-1:5], 5'(i)}] = bd[i];
      wp = w;
      we_cnt = 0;
      send_stop();
      measure_busy(inject, nb);
      chk(nb == exp_busy, {tag, " busy length R5"}, nb, exp_busy);
      repeat (3) @(negedge clk);
      chk(we_cnt == ((exp_busy != 0) ? distinct : 0), {tag, " write count R8"},
          we_cnt, (exp_busy != 0) ? distinct : 0);
      chk(mem_diff() == 0, {tag, " array contents R3"}, mem_diff(), 0);
      wp = 0;
   endtask

   initial begin
      int nb;
      void'($urandom(32'd1234));
      for (int i = 0; i < MEMSZ; i++) begin mem[i] = 0; exp_mem[i] = 0; end
      repeat (3) @(negedge clk);
      chk(busy === 1'b0, "R9 reset busy", busy, 0);
      chk(mem_we === 1'b0, "R9 reset write", mem_we, 0);
      rst_n = 1;
      @(negedge clk);

      do_seq(12'h123, 1, 0, 0, "R1 single byte");
      do_seq(12'h040, 32, 0, 0, "R1 full page");
      do_seq(12'h05C, 10, 0, 0, "R2 wrap in page");
      do_seq(12'h200, 40, 0, 0, "R2 overwrite");
      do_seq(12'h300, 0, 0, 0, "R4 dummy stop");
      do_seq(12'hC10, 5, 1, 0, "R7 locked upper");
      send_stop(); measure_busy(0, nb);
      chk(nb == 0, "R10 buffer cleared after locked stop", nb, 0);
      do_seq(12'h013, 3, 0, 0, "R10 fresh page after lock");
      do_seq(12'h010, 6, 1, 0, "R7 lower with wp");
      do_seq(12'hF00, 6, 0, 0, "R7 upper without wp");
      do_seq(12'h4E0, 7, 0, 1, "R6 inputs while busy");
      send_stop(); measure_busy(0, nb);
      chk(nb == 0, "R6 nothing staged during busy", nb, 0);

      for (int k = 0; k < 20; k++)
         do_seq(AW'($urandom), int'($urandom % 41), logic'($urandom), 0, "random");

      chk(idle_we == 0, "R8 no write while idle", idle_we, 0);
      fin = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!fin) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule